// File: doc/BRIEF.md
# Per-Channel Receive Reassembly Context Updater

This block keeps one receive context per virtual channel and updates it for every arriving cell. The channel index is taken from the cell header and addresses the context directly. For each accepted cell the block reads the channel's entry, moves the write pointer and the running packet length forward by one cell payload, and folds the 48 payload bytes into the channel's running CRC-32. It counts cells that carry a congestion mark and writes the changed fields back. Because the state is kept per channel, cells of many packets on different channels can arrive interleaved.

The host sets up each channel once, through a configuration port. Setup writes a start address, a maximum packet length and an enable bit. These fields are static: cell traffic reads them but never changes them. Setup also seeds the dynamic fields. On a cell that ends a packet, the block checks the finished CRC against the AAL5 residue and reports the result. It then returns the channel's dynamic fields to their start-of-packet values. Every update is reported once on a registered result port. A busy output holds off the next cell while an update is in progress.

Top module: `rx_ctx_updater`

## Requirements
- R1: While reset is high and after it is released, `busy` and `done_valid` are 0 until a cell is accepted.
- R2: A configuration write happens at a clock edge where `cfg_we` is 1 and `busy` is 0, and it is ignored while `busy` is 1. It stores the start address, maximum length and enable bit. It sets the channel's pointer to the start address, its length and congestion count to 0, its length-error flag to 0 and its CRC to 0xFFFFFFFF. A cell presented in the same cycle as an honoured write is not accepted in that cycle.
- R3: A cell is accepted at an edge where `cell_valid` is 1, `busy` is 0 and `cfg_we` is 0. `busy` is then 1 for exactly one cycle. A `cell_valid` held during that cycle is not taken; the held cell is accepted at the next edge where `busy` is 0.
- R4: `done_valid` pulses for one cycle at the second edge after acceptance, with `done_ch` and `done_eop` equal to the accepted cell's channel and end flag.
- R5: An enabled channel's cell adds 48 to the 28-bit pointer (wrapping modulo 2^28) and to the 16-bit length (wrapping modulo 2^16). The updated values are reported on `done_ptr` and `done_len`.
- R6: A cell with `cell_efci` = 1 adds one to the channel's 8-bit congestion count, which wraps from 255 to 0. The updated count is reported on `done_efci_cnt`.
- R7: The running CRC is updated with polynomial 0x04C11DB7, non-reflected, taking the most significant bit first. Payload byte 0 sits in bits 383:376, and the bytes are processed from byte 0 to byte 47. The updated value is reported on `done_crc`.
- R8: On an end cell, `done_crc_err` is 1 exactly when the updated CRC differs from 0xC704DD7B. `done_crc_err` is always 0 on other cells. After an end cell the channel's pointer goes back to its configured start address, and its length, count and error flag return to 0 with the CRC back at 0xFFFFFFFF.
- R9: `done_len_err` is 1 when the updated length exceeds the configured maximum, or when it was already set earlier in the same packet. It clears only when a new packet begins.
- R10: A cell on a channel whose enable bit is 0 is reported with `done_drop` = 1 and leaves the context unchanged. The reported pointer, length, count, CRC and length-error fields are the stored ones, and `done_crc_err` is 0.
- R11: Contexts of different channels are independent: cells interleaved across channels each continue their own channel's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Channel setup strobe |
| cfg_ch | input | 10 | Channel being set up |
| cfg_start_ptr | input | 28 | Start address for the channel's buffer |
| cfg_max_len | input | 16 | Largest allowed packet length in bytes |
| cfg_enable | input | 1 | Channel accepts cells when 1 |
| cell_valid | input | 1 | A cell is offered |
| cell_ch | input | 10 | Channel index from the cell header |
| cell_eop | input | 1 | Cell ends a packet |
| cell_efci | input | 1 | Cell header carries a congestion mark |
| cell_payload | input | 384 | 48 payload bytes, byte 0 in the top bits |
| busy | output | 1 | An update is in progress; no cell is taken |
| done_valid | output | 1 | Result strobe, one cycle |
| done_ch | output | 10 | Channel of the result |
| done_eop | output | 1 | Result belongs to an end cell |
| done_drop | output | 1 | Cell dropped on a disabled channel |
| done_ptr | output | 28 | Pointer after the update |
| done_len | output | 16 | Packet length after the update |
| done_efci_cnt | output | 8 | Congestion count after the update |
| done_crc | output | 32 | CRC after the update |
| done_crc_err | output | 1 | End cell failed the residue check |
| done_len_err | output | 1 | Packet exceeded its maximum length |

## Verification
The assertions assume that the host never offers a setup write while `busy` is high. They also assume that a channel is set up before its first cell arrives, because the context memories have no reset. The bench sets up every channel it uses before sending cells to it, and it raises `cfg_we` only in idle cycles, except for one deliberate cycle in which the write and a cell collide. End cells carry a correct or a deliberately spoiled CRC trailer, which the bench builds from its own model of the running CRC. A length limit is set low on one channel so that the overflow path is exercised.

// File: rtl/rx_ctx_pkg.sv
package rx_ctx_pkg;

  localparam int PTR_W = 28;
  localparam int LEN_W = 16;
  localparam int CNT_W = 8;
  localparam int CRC_W = 32;

  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;
  localparam logic [CRC_W-1:0] CRC_GOOD = 32'hC704DD7B;

  // fields rewritten by every cell
  typedef struct packed {
    logic             len_err;
    logic [CNT_W-1:0] efci_cnt;
    logic [LEN_W-1:0] len;
    logic [PTR_W-1:0] cur_ptr;
    logic [CRC_W-1:0] crc;
  } dyn_ctx_t;

  // fields written only by channel setup
  typedef struct packed {
    logic             enable;
    logic [LEN_W-1:0] max_len;
    logic [PTR_W-1:0] start_ptr;
  } stat_ctx_t;

  typedef struct packed {
    logic             drop;
    logic             crc_err;
    logic             len_err;
    logic [CNT_W-1:0] efci_cnt;
    logic [LEN_W-1:0] len;
    logic [PTR_W-1:0] ptr;
    logic [CRC_W-1:0] crc;
  } report_t;

  typedef enum logic {ST_IDLE, ST_UPD} upd_state_t;

  function automatic logic [CRC_W-1:0] crc32_byte(input logic [CRC_W-1:0] c,
                                                  input logic [7:0] b);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ b[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/rx_ctx_ram.sv
module rx_ctx_ram #(
  parameter int W      = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rx_ctx_crc.sv
module rx_ctx_crc import rx_ctx_pkg::*; #(
  parameter int NBYTES = 48
) (
  input  logic [CRC_W-1:0]    crc_in,
  input  logic [NBYTES*8-1:0] data,
  output logic [CRC_W-1:0]    crc_out
);
  always_comb begin
    logic [CRC_W-1:0] acc;
    acc = crc_in;
    for (int i = 0; i < NBYTES; i++) begin
      acc = crc32_byte(acc, data[(NBYTES-1-i)*8 +: 8]);
    end
    crc_out = acc;
  end
endmodule

// File: rtl/rx_ctx_next.sv
module rx_ctx_next import rx_ctx_pkg::*; #(
  parameter int CELL_BYTES = 48
) (
  input  dyn_ctx_t              cur,
  input  stat_ctx_t             cfg,
  input  logic                  eop,
  input  logic                  efci,
  input  logic [CELL_BYTES*8-1:0] payload,
  output dyn_ctx_t              nxt,
  output report_t               rep
);
  localparam logic [PTR_W-1:0] PTR_STEP = PTR_W'(CELL_BYTES);
  localparam logic [LEN_W-1:0] LEN_STEP = LEN_W'(CELL_BYTES);

  logic [CRC_W-1:0] crc_upd;
  logic [PTR_W-1:0] ptr_upd;
  logic [LEN_W-1:0] len_upd;
  logic [CNT_W-1:0] cnt_upd;
  logic             lerr_upd;

  rx_ctx_crc #(.NBYTES(CELL_BYTES)) u_crc (
    .crc_in (cur.crc),
    .data   (payload),
    .crc_out(crc_upd)
  );

  assign ptr_upd  = cur.cur_ptr + PTR_STEP;
  assign len_upd  = cur.len + LEN_STEP;
  assign cnt_upd  = cur.efci_cnt + CNT_W'(efci);
  assign lerr_upd = cur.len_err | (len_upd > cfg.max_len);

  always_comb begin
    if (!cfg.enable) begin
      nxt         = cur;
      rep.drop    = 1'b1;
      rep.crc_err = 1'b0;
      rep.len_err = cur.len_err;
      rep.efci_cnt = cur.efci_cnt;
      rep.len     = cur.len;
      rep.ptr     = cur.cur_ptr;
      rep.crc     = cur.crc;
    end else begin
      rep.drop     = 1'b0;
      rep.crc_err  = eop && (crc_upd != CRC_GOOD);
      rep.len_err  = lerr_upd;
      rep.efci_cnt = cnt_upd;
      rep.len      = len_upd;
      rep.ptr      = ptr_upd;
      rep.crc      = crc_upd;
      if (eop) begin
        nxt.len_err  = 1'b0;
        nxt.efci_cnt = '0;
        nxt.len      = '0;
        nxt.cur_ptr  = cfg.start_ptr;
        nxt.crc      = CRC_SEED;
      end else begin
        nxt.len_err  = lerr_upd;
        nxt.efci_cnt = cnt_upd;
        nxt.len      = len_upd;
        nxt.cur_ptr  = ptr_upd;
        nxt.crc      = crc_upd;
      end
    end
  end
endmodule

// File: rtl/rx_ctx_ctrl.sv
module rx_ctx_ctrl import rx_ctx_pkg::*; (
  input  logic clk,
  input  logic rst,
  input  logic cell_valid,
  input  logic cfg_we,
  output logic accept,
  output logic cfg_go,
  output logic busy
);
  upd_state_t st;

  assign busy   = (st == ST_UPD);
  assign cfg_go = cfg_we && (st == ST_IDLE);
  assign accept = cell_valid && (st == ST_IDLE) && !cfg_we;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else begin
      case (st)
        ST_IDLE: if (accept) st <= ST_UPD;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy); // R3
  AST_NO_TAKE_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !accept); // R3
  AST_SETUP_BLOCKS_CELL: assert property (@(posedge clk) disable iff (rst)
    cfg_go |-> !accept); // R2
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy); // R3
endmodule

// File: rtl/rx_ctx_updater.sv
module rx_ctx_updater import rx_ctx_pkg::*; #(
  parameter int CH_W       = 10,
  parameter int CELL_BYTES = 48
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [CH_W-1:0]         cfg_ch,
  input  logic [PTR_W-1:0]        cfg_start_ptr,
  input  logic [LEN_W-1:0]        cfg_max_len,
  input  logic                    cfg_enable,
  input  logic                    cell_valid,
  input  logic [CH_W-1:0]         cell_ch,
  input  logic                    cell_eop,
  input  logic                    cell_efci,
  input  logic [CELL_BYTES*8-1:0] cell_payload,
  output logic                    busy,
  output logic                    done_valid,
  output logic [CH_W-1:0]         done_ch,
  output logic                    done_eop,
  output logic                    done_drop,
  output logic [PTR_W-1:0]        done_ptr,
  output logic [LEN_W-1:0]        done_len,
  output logic [CNT_W-1:0]        done_efci_cnt,
  output logic [CRC_W-1:0]        done_crc,
  output logic                    done_crc_err,
  output logic                    done_len_err
);
  localparam int DYN_W  = $bits(dyn_ctx_t);
  localparam int STAT_W = $bits(stat_ctx_t);
  localparam int PAY_W  = CELL_BYTES * 8;

  logic accept, cfg_go;

  rx_ctx_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cell_valid(cell_valid),
    .cfg_we    (cfg_we),
    .accept    (accept),
    .cfg_go    (cfg_go),
    .busy      (busy)
  );

  // cell captured at acceptance, used in the update cycle
  logic [CH_W-1:0]  ch_q;
  logic             eop_q, efci_q;
  logic [PAY_W-1:0] pay_q;

  always_ff @(posedge clk) begin
    if (accept) begin
      ch_q   <= cell_ch;
      eop_q  <= cell_eop;
      efci_q <= cell_efci;
      pay_q  <= cell_payload;
    end
  end

  dyn_ctx_t  dyn_rd, dyn_nxt, dyn_init, dyn_wdata;
  stat_ctx_t stat_rd, stat_wdata;
  report_t   rep;
  logic      dyn_we;
  logic [CH_W-1:0] dyn_waddr;
  logic [DYN_W-1:0]  dyn_rd_raw;
  logic [STAT_W-1:0] stat_rd_raw;

  assign dyn_rd  = dyn_ctx_t'(dyn_rd_raw);
  assign stat_rd = stat_ctx_t'(stat_rd_raw);

  assign stat_wdata.enable    = cfg_enable;
  assign stat_wdata.max_len   = cfg_max_len;
  assign stat_wdata.start_ptr = cfg_start_ptr;

  assign dyn_init.len_err  = 1'b0;
  assign dyn_init.efci_cnt = '0;
  assign dyn_init.len      = '0;
  assign dyn_init.cur_ptr  = cfg_start_ptr;
  assign dyn_init.crc      = CRC_SEED;

  // setup and update never share a cycle: setup only when idle
  assign dyn_we    = cfg_go || (busy && stat_rd.enable);
  assign dyn_waddr = cfg_go ? cfg_ch : ch_q;
  assign dyn_wdata = cfg_go ? dyn_init : dyn_nxt;

  rx_ctx_ram #(.W(DYN_W), .ADDR_W(CH_W)) u_dyn_ram (
    .clk  (clk),
    .we   (dyn_we),
    .waddr(dyn_waddr),
    .wdata(dyn_wdata),
    .re   (accept),
    .raddr(cell_ch),
    .rdata(dyn_rd_raw)
  );

  rx_ctx_ram #(.W(STAT_W), .ADDR_W(CH_W)) u_stat_ram (
    .clk  (clk),
    .we   (cfg_go),
    .waddr(cfg_ch),
    .wdata(stat_wdata),
    .re   (accept),
    .raddr(cell_ch),
    .rdata(stat_rd_raw)
  );

  rx_ctx_next #(.CELL_BYTES(CELL_BYTES)) u_next (
    .cur    (dyn_rd),
    .cfg    (stat_rd),
    .eop    (eop_q),
    .efci   (efci_q),
    .payload(pay_q),
    .nxt    (dyn_nxt),
    .rep    (rep)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_valid    <= 1'b0;
      done_ch       <= '0;
      done_eop      <= 1'b0;
      done_drop     <= 1'b0;
      done_ptr      <= '0;
      done_len      <= '0;
      done_efci_cnt <= '0;
      done_crc      <= '0;
      done_crc_err  <= 1'b0;
      done_len_err  <= 1'b0;
    end else begin
      done_valid <= busy;
      if (busy) begin
        done_ch       <= ch_q;
        done_eop      <= eop_q;
        done_drop     <= rep.drop;
        done_ptr      <= rep.ptr;
        done_len      <= rep.len;
        done_efci_cnt <= rep.efci_cnt;
        done_crc      <= rep.crc;
        done_crc_err  <= rep.crc_err;
        done_len_err  <= rep.len_err;
      end
    end
  end

  AST_RESULT_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
    accept |=> ##1 done_valid); // R4
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid); // R4
  AST_CRCERR_ONLY_END: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_crc_err) |-> done_eop); // R8
  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (busy && !stat_rd.enable) |-> !dyn_we); // R10
  AST_END_RESEEDS: assert property (@(posedge clk) disable iff (rst)
    (busy && eop_q && stat_rd.enable) |-> (dyn_wdata.crc == CRC_SEED && dyn_wdata.len == '0)); // R8
  AST_SETUP_SEEDS: assert property (@(posedge clk) disable iff (rst)
    cfg_go |-> (dyn_wdata.crc == CRC_SEED && dyn_wdata.cur_ptr == cfg_start_ptr)); // R2
  AST_DROP_NO_CRCERR: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_drop) |-> !done_crc_err); // R10
endmodule

// File: tb/sim_rx_ctx_updater.sv
module sim_rx_ctx_updater;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk; // 125 MHz

  logic         cfg_we = 0, cfg_enable = 0, cell_valid = 0, cell_eop = 0, cell_efci = 0;
  logic [9:0]   cfg_ch = 0, cell_ch = 0;
  logic [27:0]  cfg_start_ptr = 0;
  logic [15:0]  cfg_max_len = 0;
  logic [383:0] cell_payload = 0;
  logic         busy, done_valid, done_eop, done_drop, done_crc_err, done_len_err;
  logic [9:0]   done_ch;
  logic [27:0]  done_ptr;
  logic [15:0]  done_len;
  logic [7:0]   done_efci_cnt;
  logic [31:0]  done_crc;

  rx_ctx_updater u0 (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  bit idle_chk = 1;

  // reference model
  logic [27:0] m_ptr [1024];
  logic [27:0] m_start [1024];
  logic [15:0] m_len [1024];
  logic [15:0] m_max [1024];
  logic [7:0]  m_cnt [1024];
  logic [31:0] m_crc [1024];
  logic        m_en [1024];
  logic        m_lerr [1024];

  logic        e_drop, e_crc_err, e_len_err;
  logic [27:0] e_ptr;
  logic [15:0] e_len;
  logic [7:0]  e_cnt;
  logic [31:0] e_crc;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c0, input logic [383:0] p, input int n);
    logic [31:0] c;
    c = c0;
    for (int i = 0; i < n; i++) begin
      c = c ^ {p[383-8*i -: 8], 24'h0};
      for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [383:0] mk_data(input int seed);
    logic [383:0] p;
    for (int i = 0; i < 48; i++) p[383-8*i -: 8] = 8'((seed * 13 + i * 29 + 7) & 255);
    return p;
  endfunction

  function automatic logic [383:0] mk_end(input int ch, input int seed, input bit bad);
    logic [383:0] p;
    logic [31:0] c;
    p = mk_data(seed);
    c = ref_crc(m_crc[ch], p, 44);
    p[31:0] = ~c;
    if (bad) p[0] = ~p[0];
    return p;
  endfunction

  task automatic mdl_cfg(input int ch, input logic [27:0] st, input logic [15:0] mx, input logic en);
    m_start[ch] = st; m_max[ch] = mx; m_en[ch] = en;
    m_ptr[ch] = st; m_len[ch] = 0; m_cnt[ch] = 0; m_crc[ch] = 32'hFFFFFFFF; m_lerr[ch] = 0;
  endtask

  task automatic mdl_cell(input int ch, input bit eop, input bit efci, input logic [383:0] p);
    if (!m_en[ch]) begin
      e_drop = 1; e_crc_err = 0; e_len_err = m_lerr[ch];
      e_ptr = m_ptr[ch]; e_len = m_len[ch]; e_cnt = m_cnt[ch]; e_crc = m_crc[ch];
    end else begin
      e_drop = 0;
      e_crc = ref_crc(m_crc[ch], p, 48);
      e_ptr = m_ptr[ch] + 28'd48;
      e_len = m_len[ch] + 16'd48;
      e_cnt = m_cnt[ch] + (efci ? 8'd1 : 8'd0);
      e_len_err = m_lerr[ch] || (e_len > m_max[ch]);
      e_crc_err = eop && (e_crc != 32'hC704DD7B);
      if (eop) begin
        m_ptr[ch] = m_start[ch]; m_len[ch] = 0; m_cnt[ch] = 0;
        m_crc[ch] = 32'hFFFFFFFF; m_lerr[ch] = 0;
      end else begin
        m_ptr[ch] = e_ptr; m_len[ch] = e_len; m_cnt[ch] = e_cnt;
        m_crc[ch] = e_crc; m_lerr[ch] = e_len_err;
      end
    end
  endtask

  task automatic chk_done(input string r, input int ch, input bit eop);
    chk({r, " done_valid"}, done_valid, 1);
    chk({r, " R4 done_ch"}, done_ch, ch[9:0]);
    chk({r, " R4 done_eop"}, done_eop, eop);
    chk({r, " R10 done_drop"}, done_drop, e_drop);
    chk({r, " R5 done_ptr"}, done_ptr, e_ptr);
    chk({r, " R5 done_len"}, done_len, e_len);
    chk({r, " R6 done_efci_cnt"}, done_efci_cnt, e_cnt);
    chk({r, " R7 done_crc"}, done_crc, e_crc);
    chk({r, " R8 done_crc_err"}, done_crc_err, e_crc_err);
    chk({r, " R9 done_len_err"}, done_len_err, e_len_err);
  endtask

  task automatic drive_cell(input int ch, input bit eop, input bit efci, input logic [383:0] p);
    cell_valid = 1; cell_ch = ch[9:0]; cell_eop = eop; cell_efci = efci; cell_payload = p;
  endtask

  task automatic do_cfg(input int ch, input logic [27:0] st, input logic [15:0] mx, input logic en);
    @(negedge clk);
    chk("R2 idle before setup", busy, 0);
    cfg_we = 1; cfg_ch = ch[9:0]; cfg_start_ptr = st; cfg_max_len = mx; cfg_enable = en;
    mdl_cfg(ch, st, mx, en);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input string r, input int ch, input bit eop, input bit efci, input logic [383:0] p);
    @(negedge clk);
    idle_chk = 0;
    chk({r, " R3 idle before cell"}, busy, 0);
    drive_cell(ch, eop, efci, p);
    mdl_cell(ch, eop, efci, p);
    @(negedge clk);
    chk({r, " R3 busy"}, busy, 1);
    chk({r, " R4 no early result"}, done_valid, 0);
    cell_valid = 0;
    @(negedge clk);
    chk({r, " R3 busy released"}, busy, 0);
    chk_done(r, ch, eop);
    idle_chk = 1;
  endtask

  // idle monitor, sampled away from the edge
  always @(posedge clk) begin
    #2;
    if (!rst && idle_chk) begin
      chk("R3 idle busy", busy, 0);
      chk("R4 idle done_valid", done_valid, 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [383:0] pa, pb;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 done_valid in reset", done_valid, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done_valid after reset", done_valid, 0);

    do_cfg(5, 28'h0100000, 16'd2000, 1);
    do_cfg(700, 28'hFFFFFE0, 16'd2000, 1);
    do_cfg(1023, 28'h0ABCDE0, 16'd2000, 0);
    do_cfg(9, 28'h0002000, 16'd60, 1);
    do_cfg(40, 28'h0300000, 16'hFFFF, 1);

    // R5 R6 R7 R11: interleaved channels
    send("R5 ch5 first", 5, 0, 1, mk_data(1));
    send("R5 ch700 wrap", 700, 0, 0, mk_data(2));
    send("R11 ch5 second", 5, 0, 0, mk_data(3));
    send("R11 ch700 second", 700, 0, 1, mk_data(4));
    // R8 good end, then next packet starts at start address
    send("R8 ch5 good end", 5, 1, 1, mk_end(5, 5, 0));
    send("R8 ch5 restart", 5, 0, 0, mk_data(6));
    send("R8 ch5 bad end", 5, 1, 0, mk_end(5, 7, 1));
    send("R8 ch700 good end", 700, 1, 0, mk_end(700, 8, 0));
    // R10 disabled channel, twice
    send("R10 drop a", 1023, 0, 1, mk_data(9));
    send("R10 drop b", 1023, 1, 0, mk_data(10));
    // R9 length limit
    send("R9 ch9 c1", 9, 0, 0, mk_data(11));
    send("R9 ch9 c2", 9, 0, 0, mk_data(12));
    send("R9 ch9 end", 9, 1, 0, mk_end(9, 13, 0));
    send("R9 ch9 fresh", 9, 0, 0, mk_data(14));
    // R6 congestion count wrap
    for (int i = 0; i < 257; i++) send("R6 wrap", 40, 0, 1, mk_data(100 + i));

    // R3 held request while busy
    pa = mk_data(20); pb = mk_data(21);
    @(negedge clk);
    idle_chk = 0;
    drive_cell(700, 0, 0, pa);
    mdl_cell(700, 0, 0, pa);
    @(negedge clk);
    chk("R3 held busy", busy, 1);
    drive_cell(5, 0, 1, pb);
    @(negedge clk);
    chk("R3 held first result", busy, 0);
    chk_done("R3 held first", 700, 0);
    mdl_cell(5, 0, 1, pb);
    @(negedge clk);
    chk("R3 held second taken", busy, 1);
    chk("R3 single result", done_valid, 0);
    cell_valid = 0;
    @(negedge clk);
    chk_done("R3 held second", 5, 0);
    idle_chk = 1;

    // R2 setup wins over cell in the same cycle
    pa = mk_data(30);
    @(negedge clk);
    idle_chk = 0;
    cfg_we = 1; cfg_ch = 10'd700; cfg_start_ptr = 28'h0500000; cfg_max_len = 16'd500; cfg_enable = 1;
    mdl_cfg(700, 28'h0500000, 16'd500, 1);
    drive_cell(700, 0, 0, pa);
    @(negedge clk);
    chk("R2 cell not taken with setup", busy, 0);
    cfg_we = 0;
    mdl_cell(700, 0, 0, pa);
    @(negedge clk);
    chk("R2 cell taken after setup", busy, 1);
    cell_valid = 0;
    @(negedge clk);
    chk_done("R2 after setup", 700, 0);
    idle_chk = 1;

    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule